// File: doc/BRIEF.md
# Circuit-Switched Path-Setup Switching Node

This block is a 4x4 switching node for a three-stage rearrangeable network that joins 16 endpoints through 4-input, 4-output switches in three columns. Traffic uses pipelined circuit switching. An upstream source holds its 1-bit request high to claim a path. The node binds that input to a free output link, passes the request downstream and returns the downstream 2-bit answer. The node keeps the crosspoint for as long as the request stays high. When the request falls, the node frees the link.

The node is written for the first column. In that column every output leads to a different middle switch, so all outputs are equal candidates. If a downstream switch answers that the link is blocked, the node drops that attempt and tries another output that is still untried. It reports blocked to its own source only when no candidate output is left. Payload words pass through the held crosspoint and cross one register on the way to the output.

Each input has its own controller with four states. IDLE waits for a request. SEEK retries after a blocked answer. LINK holds an owned output. BLOCK reports that no route exists. The transitions are as follows:
- IDLE to LINK when the request rises and an output is granted.
- IDLE to SEEK when the request rises and neither a grant nor a blocked result is given.
- IDLE to BLOCK when the request rises and no candidate output exists.
- SEEK to LINK on a grant.
- SEEK to BLOCK when no candidate is left.
- LINK to SEEK when the answer is blocked.
- Every non-idle state returns to IDLE when the request falls.

Top module: `csw_node`

## Requirements
- R1: During and right after reset, every downstream request is 0, every upstream answer is 00 and every data output is 0.
- R2: When an input in IDLE raises its request, the lowest-numbered output that is free and untried raises its downstream request after the next clock edge. Until an answer comes back, the input's answer stays 00 (idle/pending).
- R3: While an input holds a link, its answer equals the answer of its output in the same cycle, for the codes 00, 01 (ready/ack) and 11 (busy/nAck).
- R4: An nAck answer (11) does not release the path: the downstream request stays high while the upstream request stays high.
- R5: When several inputs seek in the same cycle, lower-numbered inputs choose first, and each takes the lowest-numbered output still available.
- R6: Each output link is owned by at most one input at a time.
- R7: A blocked answer (10) on a held output is shown upstream as 00. The output is released after the next edge, and one edge later the input takes the lowest-numbered output that is free and not yet tried.
- R8: When no output is both free and untried, the input's answer becomes 10 after the next edge. It stays 10 while the request stays high, even if an output frees up. After the request falls, the answer returns to 00 and the tried outputs are forgotten.
- R9: A held output keeps its request high during the cycle in which the upstream request falls. The output goes idle after the next edge, and another input can then claim it.
- R10: An output's data equals the owning input's data word, delayed by one register. An unowned output presents 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | N_PORTS | Request from each upstream link |
| ans_out | output | 2*N_PORTS | Answer to each upstream link, 2 bits per input |
| data_in | input | N_PORTS*DATA_W | Payload from each upstream link |
| req_out | output | N_PORTS | Request to each downstream link |
| ans_in | input | 2*N_PORTS | Answer from each downstream link, 2 bits per output |
| data_out | output | N_PORTS*DATA_W | Registered payload to each downstream link |

## Verification
The bench runs the following cases:
- A single request on an empty node, to show that the lowest output is chosen and that each answer code is relayed.
- A request that arrives while a higher input already holds output 0, raised together with a second request, to show that input order decides which output each one gets.
- A blocked answer on an otherwise empty node, to show retry onto the next output.
- A blocked answer while the other three outputs are owned, to show that the node reports blocked instead of retrying. This case also shows that the blocked state holds after a link frees, and that the tried set is cleared once the request drops.

// File: rtl/csw_pkg.sv
package csw_pkg;
    typedef enum logic [1:0] {
        ANS_IDLE = 2'b00,
        ANS_ACK  = 2'b01,
        ANS_BACK = 2'b10,
        ANS_NACK = 2'b11
    } ans_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEEK,
        ST_LINK,
        ST_BLOCK
    } pst_t;
endpackage

// File: rtl/csw_alloc.sv
module csw_alloc #(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     seek,
    input  logic [N-1:0]     tried [N],
    input  logic [N-1:0]     busy,
    output logic [N-1:0]     grant,
    output logic [N-1:0]     none,
    output logic [SEL_W-1:0] gsel  [N]
);
    logic [N-1:0] taken;
    logic         found;

    always_comb begin
        taken = busy;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = 1'b0;
            none[i]  = 1'b0;
            gsel[i]  = '0;
            if (seek[i]) begin
                found = 1'b0;
                for (int o = 0; o < N; o++) begin
                    if (!found && !taken[o] && !tried[i][o]) begin
                        found   = 1'b1;
                        gsel[i] = SEL_W'(o);
                    end
                end
                if (found) begin
                    grant[i]       = 1'b1;
                    taken[gsel[i]] = 1'b1;
                end else begin
                    none[i] = 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_free_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |-> (!busy[gsel[g]] && !tried[g][gsel[g]]));
    end
endmodule

// File: rtl/csw_port_fsm.sv
module csw_port_fsm
    import csw_pkg::*;
#(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic             grant,
    input  logic [SEL_W-1:0] grant_sel,
    input  logic             none,
    input  logic [1:0]       ans_back,
    output logic             seeking,
    output logic             linked,
    output logic [SEL_W-1:0] sel,
    output logic [N-1:0]     tried,
    output logic [1:0]       ans_out
);
    pst_t st, st_nx;
    logic hit_back;

    assign hit_back = (ans_t'(ans_back) == ANS_BACK);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (req_in) st_nx = grant ? ST_LINK : (none ? ST_BLOCK : ST_SEEK);
            ST_SEEK:  if (!req_in) st_nx = ST_IDLE;
                      else if (grant) st_nx = ST_LINK;
                      else if (none) st_nx = ST_BLOCK;
            ST_LINK:  if (!req_in) st_nx = ST_IDLE;
                      else if (hit_back) st_nx = ST_SEEK;
            ST_BLOCK: if (!req_in) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sel   <= '0;
            tried <= '0;
        end else begin
            st <= st_nx;
            if (st_nx == ST_IDLE)
                tried <= '0;
            else if (st == ST_LINK && st_nx == ST_SEEK)
                tried <= tried | (N'(1) << sel);
            if (grant && seeking)
                sel <= grant_sel;
        end
    end

    always_comb begin
        seeking = req_in && (st == ST_IDLE || st == ST_SEEK);
        linked  = (st == ST_LINK);
        unique case (st)
            ST_LINK:  ans_out = hit_back ? ANS_IDLE : ans_back;
            ST_BLOCK: ans_out = ANS_BACK;
            default:  ans_out = ANS_IDLE;
        endcase
    end

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && !req_in) |=> !linked);
    assert_back_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && req_in && hit_back) |=> (!linked && tried[$past(sel)]));
    assert_block_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seeking && none) |=> (ans_out == ANS_BACK));
    assert_block_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLOCK && req_in) |=> (st == ST_BLOCK));
endmodule

// File: rtl/csw_xbar.sv
module csw_xbar #(
    parameter int N      = 4,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      linked,
    input  logic [SEL_W-1:0]  sel [N],
    input  logic [N*DATA_W-1:0] data_in,
    output logic [N-1:0]      busy,
    output logic [N-1:0]      req_out,
    output logic [N*DATA_W-1:0] data_out
);
    logic [SEL_W-1:0] src   [N];
    logic [N-1:0]     claim [N];

    always_comb begin
        for (int o = 0; o < N; o++) begin
            busy[o]  = 1'b0;
            src[o]   = '0;
            claim[o] = '0;
            for (int i = 0; i < N; i++) begin
                if (linked[i] && sel[i] == SEL_W'(o)) begin
                    claim[o][i] = 1'b1;
                    busy[o]     = 1'b1;
                    src[o]      = SEL_W'(i);
                end
            end
        end
    end

    assign req_out = busy;

    for (genvar o = 0; o < N; o++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                data_out[o*DATA_W +: DATA_W] <= '0;
            else if (busy[o])
                data_out[o*DATA_W +: DATA_W] <= data_in[src[o]*DATA_W +: DATA_W];
            else
                data_out[o*DATA_W +: DATA_W] <= '0;
        end

        assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(claim[o]));
    end
endmodule

// File: rtl/csw_node.sv
module csw_node
    import csw_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        req_in,
    output logic [2*N_PORTS-1:0]      ans_out,
    input  logic [N_PORTS*DATA_W-1:0] data_in,
    output logic [N_PORTS-1:0]        req_out,
    input  logic [2*N_PORTS-1:0]      ans_in,
    output logic [N_PORTS*DATA_W-1:0] data_out
);
    localparam int SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic [N_PORTS-1:0] seeking, linked, grant, none, busy;
    logic [SEL_W-1:0]   sel   [N_PORTS];
    logic [SEL_W-1:0]   gsel  [N_PORTS];
    logic [N_PORTS-1:0] tried [N_PORTS];

    csw_alloc #(.N(N_PORTS), .SEL_W(SEL_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .seek(seeking), .tried(tried),
        .busy(busy), .grant(grant), .none(none), .gsel(gsel)
    );

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        logic [1:0] back_ans;
        assign back_ans = ans_in[2*sel[i] +: 2];

        csw_port_fsm #(.N(N_PORTS), .SEL_W(SEL_W)) u_fsm (
            .clk(clk), .rst_n(rst_n), .req_in(req_in[i]),
            .grant(grant[i]), .grant_sel(gsel[i]), .none(none[i]),
            .ans_back(back_ans), .seeking(seeking[i]), .linked(linked[i]),
            .sel(sel[i]), .tried(tried[i]), .ans_out(ans_out[2*i +: 2])
        );

        assert_ack_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ans_out[2*i +: 2] == ANS_ACK) |-> req_out[sel[i]]);
    end

    csw_xbar #(.N(N_PORTS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_xbar (
        .clk(clk), .rst_n(rst_n), .linked(linked), .sel(sel),
        .data_in(data_in), .busy(busy), .req_out(req_out), .data_out(data_out)
    );
endmodule

// File: tb/csw_node_tb.sv
module csw_node_tb;
    localparam int N = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req_in = '0;
    logic [2*N-1:0] ans_out;
    logic [N*W-1:0] data_in = '0;
    logic [N-1:0]   req_out;
    logic [2*N-1:0] ans_in = '0;
    logic [N*W-1:0] data_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    csw_node #(.N_PORTS(N), .DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .ans_out(ans_out),
        .data_in(data_in), .req_out(req_out), .ans_in(ans_in), .data_out(data_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        req_in = '0; ans_in = '0; data_in = '0;
        step(); step();
    endtask

    task automatic t_reset();
        check("R1 req_out in reset", 64'(req_out), 64'h0);
        check("R1 ans_out in reset", 64'(ans_out), 64'h0);
        check("R1 data_out in reset", 64'(data_out), 64'h0);
        @(negedge clk); rst_n = 1'b1;
        step();
        check("R1 req_out after reset", 64'(req_out), 64'h0);
    endtask

    task automatic t_setup();
        req_in[0] = 1'b1;
        step();
        check("R2 lowest output claimed", 64'(req_out), 64'b0001);
        check("R2 pending answer", 64'(ans_out[1:0]), 64'b00);
        ans_in[1:0] = 2'b01; #1;
        check("R3 ack relayed", 64'(ans_out[1:0]), 64'b01);
        data_in[W-1:0] = 16'hA5C3;
        step();
        check("R10 data through crosspoint", 64'(data_out), 64'hA5C3);
        ans_in[1:0] = 2'b11; #1;
        check("R3 nAck relayed", 64'(ans_out[1:0]), 64'b11);
        step();
        check("R4 nAck keeps path", 64'(req_out), 64'b0001);
        req_in[0] = 1'b0; ans_in = '0; #1;
        check("R9 held during fall cycle", 64'(req_out), 64'b0001);
        step();
        check("R9 released after edge", 64'(req_out), 64'b0000);
        step();
        check("R10 unowned output zero", 64'(data_out), 64'h0);
        clear_all();
    endtask

    task automatic t_priority();
        req_in[2] = 1'b1;
        step();
        check("R5 lone input2 takes out0", 64'(req_out), 64'b0001);
        req_in[0] = 1'b1; req_in[1] = 1'b1;
        step();
        check("R5 both granted", 64'(req_out), 64'b0111);
        data_in[0*W +: W] = 16'h1111;
        data_in[1*W +: W] = 16'h2222;
        data_in[2*W +: W] = 16'h3333;
        step();
        check("R5 input0 on out1", 64'(data_out[1*W +: W]), 64'h1111);
        check("R5 input1 on out2", 64'(data_out[2*W +: W]), 64'h2222);
        check("R10 input2 on out0", 64'(data_out[0*W +: W]), 64'h3333);
        clear_all();
    endtask

    task automatic t_retry();
        req_in[0] = 1'b1;
        step();
        check("R2 out0 claimed", 64'(req_out), 64'b0001);
        ans_in[1:0] = 2'b10; #1;
        check("R7 back hidden upstream", 64'(ans_out[1:0]), 64'b00);
        step();
        check("R7 attempt released", 64'(req_out), 64'b0000);
        step();
        check("R7 retry on out1", 64'(req_out), 64'b0010);
        ans_in[3:2] = 2'b01; #1;
        check("R7 ack after retry", 64'(ans_out[1:0]), 64'b01);
        clear_all();
    endtask

    task automatic t_block();
        req_in[3:1] = 3'b111;
        step();
        check("R5 three inputs placed", 64'(req_out), 64'b0111);
        req_in[0] = 1'b1;
        step();
        check("R6 one owner per output", 64'(req_out), 64'b1111);
        ans_in[7:6] = 2'b10;
        step();
        check("R7 out3 released", 64'(req_out), 64'b0111);
        check("R8 seeking shows idle", 64'(ans_out[1:0]), 64'b00);
        step();
        check("R8 blocked reported", 64'(ans_out[1:0]), 64'b10);
        ans_in = '0;
        req_in[3] = 1'b0;
        step();
        check("R9 out2 freed", 64'(req_out), 64'b0011);
        check("R8 block held", 64'(ans_out[1:0]), 64'b10);
        req_in[0] = 1'b0;
        step();
        check("R8 block cleared", 64'(ans_out[1:0]), 64'b00);
        req_in[0] = 1'b1;
        step();
        check("R8 tried set forgotten", 64'(req_out), 64'b0111);
        clear_all();
        check("R9 all idle", 64'(req_out), 64'b0000);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #5;
        t_reset();
        t_setup();
        t_priority();
        t_retry();
        t_block();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule